// File: doc/BRIEF.md
# Synchronous FIFO with Hysteresis Level Flags

This block is a single-clock first-in first-out buffer that stores words written on one port and returns them in the same order on a read port. Along with the data it reports its fill level in two ways: a stored-word count, and a set of registered flags. The flags are full, empty, one-slot-left, one-word-left, a programmable high-water flag and a programmable low-water flag.

The two programmable flags have two modes, chosen by a parameter. In single-level mode each flag compares the count against one threshold. In dual-level mode each flag has a separate switch-on level and switch-off level. Between those two levels the flag keeps its previous value, which stops it toggling when traffic hovers around one level. A synchronous clear input empties the buffer in one cycle.

Writes into a full buffer and reads from an empty buffer are dropped without side effects. All flags are computed from the count that results from the current cycle's operation, so they change in the same cycle as the count.

Top module: `fifo_hyst_flags`

## Requirements
- R1: `level` equals accepted writes minus accepted reads since the last reset or clear, always within 0 to DEPTH (DEPTH = 2**AW).
- R2: `full` is high exactly when `level` is DEPTH, and `empty` is high exactly when `level` is 0. Both flags update in the same cycle as `level`. After reset, `empty` is high.
- R3: `one_slot_left` is high exactly when `level` is DEPTH-1, and `one_word_left` is high exactly when `level` is 1.
- R4: In single-level mode (DUAL_LVL=0), `hi_water` is high when `level` >= `hi_on` and `lo_water` is high when `level` <= `lo_on`. `hi_on` must be at least 1.
- R5: In dual-level mode (DUAL_LVL=1), `hi_water` sets when `level` >= `hi_on`. Once set, it clears only when `level` <= `hi_off`, and in between it keeps its value.
- R6: In dual-level mode, `lo_water` sets when `level` <= `lo_on`. Once set, it clears only when `level` >= `lo_off`, and in between it keeps its value.
- R7: A write while `full` is dropped: `level` and the stored words do not change. A read while `empty` is dropped: `level` and `rd_data` do not change.
- R8: When `wr_en` and `rd_en` are both high and neither is blocked, both operations take effect and `level` is unchanged. When the buffer is full only the read is taken. When it is empty only the write is taken.
- R9: `rd_data` is registered. It presents the oldest stored word in the cycle after an accepted read, holds its value otherwise, and words leave in write order.
- R10: A high `flush` wins over `wr_en` and `rd_en`. In the next cycle `level` is 0, `empty` and `lo_water` are high, and all other flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous clear of contents and flags |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Registered read word |
| level | output | AW+1 | Stored-word count |
| full | output | 1 | No free slot |
| empty | output | 1 | No stored word |
| one_slot_left | output | 1 | Exactly one free slot |
| one_word_left | output | 1 | Exactly one stored word |
| hi_water | output | 1 | Programmable high-water flag |
| lo_water | output | 1 | Programmable low-water flag |
| hi_on | input | AW+1 | High-water switch-on level |
| hi_off | input | AW+1 | High-water switch-off level (dual mode) |
| lo_on | input | AW+1 | Low-water switch-on level |
| lo_off | input | AW+1 | Low-water switch-off level (dual mode) |

## Verification
A read and a write can fall in the same cycle. The bench provokes this at three fill states: partly full, full, and empty. A behavioural queue model decides each cycle which of the two operations is legal, and the count, every flag and the read word are compared after each edge. A clear is also raised together with both requests, to show that it wins. Two instances, one per threshold mode, receive identical stimulus. This lets the hysteresis band be crossed in both directions and judged against the single-level reading of the same count.

// File: rtl/fhf_pkg.sv
package fhf_pkg;

  // Count after one cycle, given which operations were accepted.
  function automatic int unsigned fhf_count_next(int unsigned cnt, logic wr_take, logic rd_take);
    int unsigned n;
    n = cnt;
    if (wr_take && !rd_take) n = cnt + 1;
    if (rd_take && !wr_take) n = cnt - 1;
    return n;
  endfunction

  // High-water flag next state; dual selects the hysteresis rule.
  function automatic logic fhf_hi_next(logic dual, logic cur, int unsigned n,
                                       int unsigned on_lvl, int unsigned off_lvl);
    if (!dual) return n >= on_lvl;
    if (cur)   return n > off_lvl;
    return n >= on_lvl;
  endfunction

  // Low-water flag next state; dual selects the hysteresis rule.
  function automatic logic fhf_lo_next(logic dual, logic cur, int unsigned n,
                                       int unsigned on_lvl, int unsigned off_lvl);
    if (!dual) return n <= on_lvl;
    if (cur)   return n < off_lvl;
    return n <= on_lvl;
  endfunction

endpackage

// File: rtl/fhf_level.sv
module fhf_level #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          wr_take,
  output logic          rd_take,
  output logic [AW:0]   cnt_nxt,
  output logic [AW:0]   cnt
);
  import fhf_pkg::*;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = AW + 1;

  logic at_top, at_bot;
  assign at_top  = (cnt == CW'(DEPTH));
  assign at_bot  = (cnt == '0);
  assign wr_take = wr_en & ~at_top & ~flush;
  assign rd_take = rd_en & ~at_bot & ~flush;
  assign cnt_nxt = flush ? '0 : CW'(fhf_count_next(32'(cnt), wr_take, rd_take));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R7
  blocked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && wr_en && !rd_en && !flush) |=> (cnt == CW'(DEPTH)));

  // R7
  blocked_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_bot && rd_en && !wr_en && !flush) |=> (cnt == '0));

  // R8
  both_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !at_top && !at_bot && !flush) |=> $stable(cnt));

  // R10
  flush_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0));

endmodule

// File: rtl/fhf_store.sv
module fhf_store #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_take,
  input  logic          rd_take,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (wr_take) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      rd_data <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_take) wptr <= wptr + 1'b1;
      if (rd_take) begin
        rptr    <= rptr + 1'b1;
        rd_data <= mem[rptr];
      end
    end
  end

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_take |=> $stable(rd_data));

endmodule

// File: rtl/fhf_flags.sv
module fhf_flags #(
  parameter int AW       = 4,
  parameter bit DUAL_LVL = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic [AW:0] cnt_nxt,
  input  logic [AW:0] cnt,
  input  logic [AW:0] hi_on,
  input  logic [AW:0] hi_off,
  input  logic [AW:0] lo_on,
  input  logic [AW:0] lo_off,
  output logic        full,
  output logic        empty,
  output logic        one_slot_left,
  output logic        one_word_left,
  output logic        hi_water,
  output logic        lo_water
);
  import fhf_pkg::*;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = AW + 1;

  logic hi_nxt, lo_nxt;
  assign hi_nxt = fhf_hi_next(DUAL_LVL, hi_water, 32'(cnt_nxt), 32'(hi_on), 32'(hi_off));
  assign lo_nxt = fhf_lo_next(DUAL_LVL, lo_water, 32'(cnt_nxt), 32'(lo_on), 32'(lo_off));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full          <= 1'b0;
      empty         <= 1'b1;
      one_slot_left <= 1'b0;
      one_word_left <= 1'b0;
      hi_water      <= 1'b0;
      lo_water      <= 1'b1;
    end else if (flush) begin
      full          <= 1'b0;
      empty         <= 1'b1;
      one_slot_left <= 1'b0;
      one_word_left <= 1'b0;
      hi_water      <= 1'b0;
      lo_water      <= 1'b1;
    end else begin
      full          <= (cnt_nxt == CW'(DEPTH));
      empty         <= (cnt_nxt == '0);
      one_slot_left <= (cnt_nxt == CW'(DEPTH - 1));
      one_word_left <= (cnt_nxt == CW'(1));
      hi_water      <= hi_nxt;
      lo_water      <= lo_nxt;
    end
  end

  // R2
  full_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full == (cnt == CW'(DEPTH)));

  // R2
  empty_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (cnt == '0));

  // R3
  edge_flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({full, empty, one_slot_left, one_word_left}));

  // R10
  flush_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && lo_water && !hi_water && !full));

  generate
    if (DUAL_LVL) begin : g_dual_chk
      // R5
      hi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_water) |-> (cnt >= $past(hi_on)));
      // R5
      hi_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hi_water) |-> (cnt <= $past(hi_off)));
      // R6
      lo_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lo_water) |-> (cnt >= $past(lo_off)));
    end else begin : g_single_chk
      // R4
      hi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_water == (cnt >= $past(hi_on)));
      // R4
      lo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_water == (cnt <= $past(lo_on)));
    end
  endgenerate

endmodule

// File: rtl/fifo_hyst_flags.sv
module fifo_hyst_flags #(
  parameter int AW       = 4,
  parameter int DW       = 16,
  parameter bit DUAL_LVL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [AW:0]   level,
  output logic          full,
  output logic          empty,
  output logic          one_slot_left,
  output logic          one_word_left,
  output logic          hi_water,
  output logic          lo_water,
  input  logic [AW:0]   hi_on,
  input  logic [AW:0]   hi_off,
  input  logic [AW:0]   lo_on,
  input  logic [AW:0]   lo_off
);
  logic        wr_take, rd_take;
  logic [AW:0] cnt_nxt;

  fhf_level #(.AW(AW)) u_level (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .rd_en(rd_en),
    .wr_take(wr_take), .rd_take(rd_take), .cnt_nxt(cnt_nxt), .cnt(level)
  );

  fhf_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_take(wr_take), .rd_take(rd_take),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  fhf_flags #(.AW(AW), .DUAL_LVL(DUAL_LVL)) u_flags (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cnt_nxt(cnt_nxt), .cnt(level),
    .hi_on(hi_on), .hi_off(hi_off), .lo_on(lo_on), .lo_off(lo_off),
    .full(full), .empty(empty), .one_slot_left(one_slot_left),
    .one_word_left(one_word_left), .hi_water(hi_water), .lo_water(lo_water)
  );

endmodule

// File: tb/fifo_hyst_flags_tb.sv
module fifo_hyst_flags_tb;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [AW:0] hi_on = 5'd12, hi_off = 5'd8, lo_on = 5'd3, lo_off = 5'd6;

  logic [DW-1:0] rd_d, rd_s;
  logic [AW:0]   lvl_d, lvl_s;
  logic f_d, e_d, af_d, ae_d, hw_d, lw_d;
  logic f_s, e_s, af_s, ae_s, hw_s, lw_s;

  always #4 clk = ~clk;

  fifo_hyst_flags #(.AW(AW), .DW(DW), .DUAL_LVL(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_d), .level(lvl_d), .full(f_d), .empty(e_d),
    .one_slot_left(af_d), .one_word_left(ae_d), .hi_water(hw_d), .lo_water(lw_d),
    .hi_on(hi_on), .hi_off(hi_off), .lo_on(lo_on), .lo_off(lo_off)
  );

  fifo_hyst_flags #(.AW(AW), .DW(DW), .DUAL_LVL(1'b0)) u_dut_single (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_s), .level(lvl_s), .full(f_s), .empty(e_s),
    .one_slot_left(af_s), .one_word_left(ae_s), .hi_water(hw_s), .lo_water(lw_s),
    .hi_on(hi_on), .hi_off(hi_off), .lo_on(lo_on), .lo_off(lo_off)
  );

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] m_rd = '0;
  bit m_hi = 0, m_lo = 1;
  logic [DW-1:0] next_word = 16'h1000;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int n;
    n = q.size();
    chk("R1", "level", int'(lvl_d), n);
    chk("R1", "level_single", int'(lvl_s), n);
    chk("R2", "full", int'(f_d), int'(n == DEPTH));
    chk("R2", "empty", int'(e_d), int'(n == 0));
    chk("R3", "one_slot_left", int'(af_d), int'(n == DEPTH - 1));
    chk("R3", "one_word_left", int'(ae_d), int'(n == 1));
    chk("R9", "rd_data", int'(rd_d), int'(m_rd));
    chk("R9", "rd_data_single", int'(rd_s), int'(m_rd));
    chk("R5", "hi_water_dual", int'(hw_d), int'(m_hi));
    chk("R6", "lo_water_dual", int'(lw_d), int'(m_lo));
    chk("R4", "hi_water_single", int'(hw_s), int'(n >= int'(hi_on)));
    chk("R4", "lo_water_single", int'(lw_s), int'(n <= int'(lo_on)));
  endtask

  // Drive at negedge, model the edge, compare at the following negedge.
  task automatic step(bit w, bit r, bit c);
    bit wok, rok;
    int n;
    wr_en = w; rd_en = r; flush = c;
    wr_data = next_word;
    @(posedge clk);
    if (c) begin
      q.delete();
      m_hi = 0;
      m_lo = 1;
    end else begin
      wok = w && (q.size() < DEPTH);
      rok = r && (q.size() > 0);
      if (rok) m_rd = q.pop_front();
      if (wok) q.push_back(wr_data);
      n = q.size();
      m_hi = m_hi ? (n > int'(hi_off)) : (n >= int'(hi_on));
      m_lo = m_lo ? (n < int'(lo_off)) : (n <= int'(lo_on));
    end
    if (w) next_word = next_word + 16'h0101;
    @(negedge clk);
    wr_en = 0; rd_en = 0; flush = 0;
    compare_all();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2 R10: reset state
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    // R1 R3 R4 R5: fill past every level; last write is dropped (R7)
    for (int i = 0; i < DEPTH + 1; i++) step(1, 0, 0);
    // R8: both at full -> read only
    step(1, 1, 0);
    // R5: drain through the hysteresis band and on to empty
    for (int i = 0; i < DEPTH - 1; i++) step(0, 1, 0);
    // R7: reads while empty are dropped
    step(0, 1, 0);
    step(0, 1, 0);
    // R8: both at empty -> write only
    step(1, 1, 0);
    // R6: climb through the low band
    for (int i = 0; i < 9; i++) step(1, 0, 0);
    // R8: both mid-level, count holds
    for (int i = 0; i < 4; i++) step(1, 1, 0);
    // R5: reach 12, fall to 9 (still high), 8 (low), rise to 11 (still low)
    step(1, 0, 0); step(1, 0, 0);
    step(0, 1, 0); step(0, 1, 0); step(0, 1, 0); step(0, 1, 0);
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    // R10: flush wins over both requests
    step(1, 1, 1);
    step(0, 1, 0);
    // R6: low band after flush: rise to 5 (still low), 6 (clears), fall to 4 (still clear)
    for (int i = 0; i < 6; i++) step(1, 0, 0);
    step(0, 1, 0); step(0, 1, 0);
    for (int i = 0; i < 6; i++) step(0, 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule